// File: doc/BRIEF.md
# Audio FIFO with Threshold DMA Events

This block sits between the serial audio pin logic and a DMA engine and holds up to 64 words of 32 bits. In receive mode the pin side pushes words in and the DMA reads them out; in transmit mode the DMA writes words in and the pin side pops them out. The `tx_mode` input picks the direction and is held static between resets.

The DMA is paced by events. Each time a programmed threshold number of words has moved on the pin side, one event is owed to the DMA. Each time the DMA has moved that many words on its own side, one owed event is retired. The owed events are held in a counter, so an event raised in the same cycle as another is retired is never lost. `dma_evt` is high while any event is owed.

A write to a full FIFO or a read from an empty FIFO is reported on a sticky flag. A threshold write clears both flags and restarts the progress towards the next event on both sides.

Top module: `audio_fifo_evt`

## Requirements
- R1: Words leave in the order they entered. With `tx_mode`=0, `pin_push` writes `pin_wdata` and `dma_rd` reads. With `tx_mode`=1, `dma_wr` writes `dma_wdata` and `pin_pop` reads. Strobes of the other pair have no effect.
- R2: `rd_data` shows the oldest stored word combinationally, and shows zero while the FIFO is empty.
- R3: A write while 64 words are stored is dropped, and `ovf` goes high on the next cycle and stays high.
- R4: A read while the FIFO is empty removes nothing, and `unf` goes high on the next cycle and stays high.
- R5: A cycle with `thr_we`=1 clears `ovf` and `unf`, unless a new overflow or underflow happens in that same cycle, which wins.
- R6: `thr_we` loads `thr_val` as the threshold only when the value is 1 to 32. Any other value leaves the threshold unchanged. The threshold is 1 after reset.
- R7: Each accepted pin-side transfer (a push in receive mode, a pop in transmit mode) counts towards the threshold. On every threshold-th one an event becomes owed. The count restarts at reset and at every `thr_we` cycle, and a transfer in a `thr_we` cycle is not counted.
- R8: Accepted DMA-side transfers are counted the same way. Every threshold-th one retires one owed event. When no event is owed, this retirement is ignored.
- R9: When an event becomes owed in the same cycle as one is retired, the owed count is unchanged. When none was owed, the new event stands. `dma_evt` is high after such a cycle.
- R10: `dma_evt` is high exactly while the owed count is nonzero. It rises the cycle after the transfer that completes a threshold.
- R11: After reset the FIFO is empty, `dma_evt`, `ovf` and `unf` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | 0 receive, 1 transmit |
| pin_push | input | 1 | Pin-side write strobe (receive) |
| pin_pop | input | 1 | Pin-side read strobe (transmit) |
| pin_wdata | input | 32 | Pin-side write data |
| dma_wr | input | 1 | DMA write strobe (transmit) |
| dma_rd | input | 1 | DMA read strobe (receive) |
| dma_wdata | input | 32 | DMA write data |
| thr_we | input | 1 | Threshold write; also clears flags |
| thr_val | input | 6 | Threshold value |
| rd_data | output | 32 | Oldest word, zero when empty |
| dma_evt | output | 1 | DMA event request |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach is the one where a pin-side threshold completes in the same cycle that a DMA-side threshold completes. Both progress counts must sit one short of the threshold while exactly one event is owed. Directed stimulus gets there by setting the threshold to 4 and pushing four words. It then reads three and pushes three, and then strobes a push and a read together. Long stretches of random strobes follow in both modes, with occasional threshold writes that include illegal values. These hit the coincidence again, both with and without an owed event, and also fill and drain the FIFO past full and empty.

// File: rtl/audio_fifo_evt.sv
module audio_fifo_evt #(
  parameter int DW      = 32,
  parameter int DEPTH   = 64,
  parameter int THR_MAX = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_mode,
  input  logic          pin_push,
  input  logic          pin_pop,
  input  logic [DW-1:0] pin_wdata,
  input  logic          dma_wr,
  input  logic          dma_rd,
  input  logic [DW-1:0] dma_wdata,
  input  logic          thr_we,
  input  logic [$clog2(THR_MAX+1)-1:0] thr_val,
  output logic [DW-1:0] rd_data,
  output logic          dma_evt,
  output logic          ovf,
  output logic          unf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(THR_MAX + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, owed;
  logic [TW-1:0] thr, pin_cnt, dma_cnt;

  logic          wr_req, rd_req, full, empty, wr_ok, rd_ok;
  logic          pin_xfer, dma_xfer, set_evt, clr_evt, thr_ok;
  logic [DW-1:0] wdata;

  assign wr_req   = tx_mode ? dma_wr : pin_push;
  assign rd_req   = tx_mode ? pin_pop : dma_rd;
  assign wdata    = tx_mode ? dma_wdata : pin_wdata;
  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign wr_ok    = wr_req && !full;
  assign rd_ok    = rd_req && !empty;
  assign pin_xfer = tx_mode ? rd_ok : wr_ok;
  assign dma_xfer = tx_mode ? wr_ok : rd_ok;
  assign set_evt  = pin_xfer && !thr_we && (TW'(pin_cnt + 1'b1) == thr);
  assign clr_evt  = dma_xfer && !thr_we && (TW'(dma_cnt + 1'b1) == thr);
  assign thr_ok   = (thr_val != '0) && (thr_val <= TW'(THR_MAX));

  assign rd_data  = empty ? '0 : mem[rp];
  assign dma_evt  = (owed != '0);

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      count <= count + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr     <= TW'(1);
      pin_cnt <= '0;
      dma_cnt <= '0;
    end else if (thr_we) begin
      if (thr_ok) thr <= thr_val;
      pin_cnt <= '0;
      dma_cnt <= '0;
    end else begin
      if (pin_xfer) pin_cnt <= set_evt ? '0 : pin_cnt + 1'b1;
      if (dma_xfer) dma_cnt <= clr_evt ? '0 : dma_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owed <= '0;
    else if (set_evt && !(clr_evt && dma_evt)) owed <= owed + 1'b1;
    else if (!set_evt && clr_evt && dma_evt)   owed <= owed - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= (ovf && !thr_we) || (wr_req && full);
      unf <= (unf && !thr_we) || (rd_req && empty);
    end
  end
endmodule

// File: rtl/audio_fifo_evt_chk.sv
module audio_fifo_evt_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          thr_we,
  input logic          wr_req,
  input logic          rd_req,
  input logic          full,
  input logic          empty,
  input logic          set_evt,
  input logic          clr_evt,
  input logic          dma_evt,
  input logic          ovf,
  input logic          unf,
  input logic [CW-1:0] count
);
  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !thr_we |=> ovf);
  assert_drop_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && full && !rd_req |=> $stable(count));
  assert_unf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unf && !thr_we |=> unf);
  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && empty && !wr_req |=> $stable(count));
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we && !(wr_req && full) && !(rd_req && empty) |=> !ovf && !unf);
  assert_coincide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt && clr_evt |=> dma_evt);
  assert_evt_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_evt) |-> $past(set_evt));
endmodule

bind audio_fifo_evt audio_fifo_evt_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .wr_req(wr_req), .rd_req(rd_req),
  .full(full), .empty(empty), .set_evt(set_evt), .clr_evt(clr_evt),
  .dma_evt(dma_evt), .ovf(ovf), .unf(unf), .count(count)
);

// File: tb/tb_audio_fifo_evt.sv
module tb_audio_fifo_evt;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, tx_mode = 1'b0;
  logic        pin_push = 0, pin_pop = 0, dma_wr = 0, dma_rd = 0, thr_we = 0;
  logic [31:0] pin_wdata = 0, dma_wdata = 0;
  logic [5:0]  thr_val = 0;
  logic [31:0] rd_data;
  logic        dma_evt, ovf, unf;

  audio_fifo_evt dut (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode),
    .pin_push(pin_push), .pin_pop(pin_pop), .pin_wdata(pin_wdata),
    .dma_wr(dma_wr), .dma_rd(dma_rd), .dma_wdata(dma_wdata),
    .thr_we(thr_we), .thr_val(thr_val),
    .rd_data(rd_data), .dma_evt(dma_evt), .ovf(ovf), .unf(unf)
  );

  int errors = 0, checks = 0;
  logic [31:0] mq[$];
  int m_owed, m_pc, m_dc, m_thr;
  bit m_ovf, m_unf;
  logic [31:0] seq = 32'h1000;
  logic [31:0] lfsr = 32'h1ACE5EED;

  function automatic logic [31:0] rnd();
    lfsr = lfsr * 32'd1664525 + 32'd1013904223;
    return lfsr;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R10", {31'b0, dma_evt}, {31'b0, m_owed != 0});
    chk("R3", {31'b0, ovf}, {31'b0, m_ovf});
    chk("R4", {31'b0, unf}, {31'b0, m_unf});
    if (mq.size() != 0) chk("R1", rd_data, mq[0]);
    else                chk("R2", rd_data, 32'h0);
  endtask

  task automatic model_update();
    bit wr, rd, full, empty, wr_ok, rd_ok, pin_x, dma_x, s, c;
    logic [31:0] wd;
    wr = tx_mode ? dma_wr : pin_push;
    rd = tx_mode ? pin_pop : dma_rd;
    wd = tx_mode ? dma_wdata : pin_wdata;
    full = (mq.size() == 64);
    empty = (mq.size() == 0);
    wr_ok = wr && !full;
    rd_ok = rd && !empty;
    pin_x = tx_mode ? rd_ok : wr_ok;
    dma_x = tx_mode ? wr_ok : rd_ok;
    s = 0; c = 0;
    if (thr_we) begin
      if (thr_val >= 1 && thr_val <= 32) m_thr = int'(thr_val);
      m_pc = 0; m_dc = 0;
    end else begin
      if (pin_x) begin m_pc++; if (m_pc == m_thr) begin s = 1; m_pc = 0; end end
      if (dma_x) begin m_dc++; if (m_dc == m_thr) begin c = 1; m_dc = 0; end end
    end
    if (c && m_owed > 0) m_owed--;
    if (s) m_owed++;
    m_ovf = (m_ovf && !thr_we) || (wr && full);
    m_unf = (m_unf && !thr_we) || (rd && empty);
    if (rd_ok) void'(mq.pop_front());
    if (wr_ok) mq.push_back(wd);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(bit p_push, bit p_pop, bit d_wr, bit d_rd);
    pin_push = p_push; pin_pop = p_pop; dma_wr = d_wr; dma_rd = d_rd;
    seq = seq + 1; pin_wdata = seq; dma_wdata = ~seq;
    cyc();
    pin_push = 0; pin_pop = 0; dma_wr = 0; dma_rd = 0;
  endtask

  task automatic thr_write(logic [5:0] v);
    thr_we = 1; thr_val = v;
    cyc();
    thr_we = 0;
  endtask

  task automatic do_reset(bit mode);
    rst_n = 0; tx_mode = mode;
    pin_push = 0; pin_pop = 0; dma_wr = 0; dma_rd = 0; thr_we = 0;
    repeat (2) @(posedge clk);
    mq.delete(); m_owed = 0; m_pc = 0; m_dc = 0; m_thr = 1; m_ovf = 0; m_unf = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R11", {29'b0, dma_evt, ovf, unf}, 32'h0);
    chk("R11", rd_data, 32'h0);
  endtask

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      r = rnd();
      pin_push = r[0] | r[1]; pin_pop = r[2] | r[3];
      dma_wr = r[4] & r[5]; dma_rd = r[6] & r[7];
      if (tx_mode) begin dma_wr = r[4] | r[5]; dma_rd = r[6] & r[7]; end
      thr_we = (r[15:9] == 0);
      thr_val = 6'(r[23:16] % 41);
      seq = seq + 1; pin_wdata = seq; dma_wdata = ~seq;
      cyc();
    end
    pin_push = 0; pin_pop = 0; dma_wr = 0; dma_rd = 0; thr_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    drive(1, 0, 0, 0);
    chk("R7", {31'b0, dma_evt}, 32'h1);
    drive(0, 0, 0, 1);
    chk("R8", {31'b0, dma_evt}, 32'h0);
    thr_write(6'd0);
    drive(1, 0, 0, 0);
    chk("R6", {31'b0, dma_evt}, 32'h1);
    drive(0, 0, 0, 1);
    thr_write(6'd4);
    repeat (3) drive(1, 0, 0, 0);
    chk("R7", {31'b0, dma_evt}, 32'h0);
    drive(1, 0, 0, 0);
    chk("R7", {31'b0, dma_evt}, 32'h1);
    repeat (3) drive(0, 0, 0, 1);
    repeat (3) drive(1, 0, 0, 0);
    drive(1, 0, 0, 1);
    chk("R9", {31'b0, dma_evt}, 32'h1);
    repeat (3) drive(0, 0, 0, 1);
    chk("R8", {31'b0, dma_evt}, 32'h1);
    drive(0, 0, 0, 1);
    chk("R8", {31'b0, dma_evt}, 32'h0);
    drive(0, 0, 0, 1);
    chk("R4", {31'b0, unf}, 32'h1);
    chk("R2", rd_data, 32'h0);
    thr_write(6'd32);
    chk("R5", {31'b0, unf}, 32'h0);
    repeat (70) drive(1, 0, 1, 0);
    chk("R3", {31'b0, ovf}, 32'h1);
    thr_write(6'd40);
    chk("R5", {31'b0, ovf}, 32'h0);
    repeat (32) drive(0, 1, 0, 1);
    chk("R8", {31'b0, dma_evt}, 32'h1);
    repeat (32) drive(0, 0, 0, 1);
    chk("R6", {31'b0, dma_evt}, 32'h0);
    random_phase(3000);

    do_reset(1'b1);
    thr_write(6'd4);
    repeat (8) drive(0, 0, 1, 1);
    chk("R8", {31'b0, dma_evt}, 32'h0);
    repeat (4) drive(0, 1, 0, 0);
    chk("R7", {31'b0, dma_evt}, 32'h1);
    random_phase(3000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule